// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block is the receive half of an asynchronous serial port. A free-running baud enable, supplied from outside at sixteen pulses per bit, paces a sampler that finds the falling edge of a start bit and confirms it at mid-bit. The sampler then picks each following bit at its centre. The frame shape is set at run time: 7 or 8 data bits, least significant bit first; no parity, even parity or odd parity; and 1 or 2 stop bits. Each received character is written into a 16-deep queue together with two flags of its own, one for a parity mismatch and one for a bad stop bit.

Software or a DMA engine drains the queue through a show-ahead read port. The block keeps two live counts: the number of characters held and the number of held characters that carry an error flag. From these it raises a receive-ready request at a selectable fill threshold, an error request, and a flow-control output that tells the far end to pause. It also recognises a line break, flags data that has sat in the queue through a long idle gap, and records an overrun when a character arrives while the queue is full.

Top module: `serial_rx_errfifo`

## Requirements
- R1: A low level on the line counts as a start bit only if it is still low 8 baud ticks after it was first seen. A shorter low pulse stores nothing.
- R2: Data bits arrive least significant bit first. With `cfg_seven_bit`=1, seven data bits are taken and bit 7 of the stored byte is 0. With `cfg_seven_bit`=0, eight data bits are taken.
- R3: With `cfg_parity_en`=1, one parity bit follows the data. Its expected value makes the count of ones over data plus parity even when `cfg_parity_odd`=0 and odd when `cfg_parity_odd`=1. A mismatch sets that entry's parity flag. With `cfg_parity_en`=0, no parity bit is expected and the flag is always 0.
- R4: A first stop bit sampled low sets that entry's framing flag. With `cfg_two_stop`=1, characters framed with two stop bits are received without error.
- R5: Characters are stored and read in arrival order, up to 16 entries. `rd_data`, `rd_parity_err` and `rd_frame_err` show the oldest entry. A one-cycle `rd_pop` removes it when the queue is not empty. `fill_level` gives the entry count.
- R6: `err_entries` equals the number of stored entries with either flag set. `irq_rx_err` is high exactly when that count is not zero.
- R7: `irq_rx_full` is high when `fill_level` is at or above the threshold chosen by `cfg_full_sel`: 0 selects 1, 1 selects 4, 2 selects 8, 3 selects 14.
- R8: `rts` is 1 (far end may send) while `fill_level` is below 14, and 0 otherwise.
- R9: A character completed while the queue holds 16 entries is discarded. `overrun` is then set and stays set until reset.
- R10: After a framing error, if the line stays low for one further full frame time, `irq_break` goes high. It stays high until the line returns high. A framing error followed by a high line raises no break.
- R11: `rx_timeout` goes high when the queue is not empty and no start bit has been seen for 1.5 frame times (24 ticks per frame bit) since the last store or read. A read or a new character clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling enable, 16 pulses per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_seven_bit | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_parity_en | input | 1 | 1 expects a parity bit |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_full_sel | input | 2 | Receive-ready threshold select |
| rd_pop | input | 1 | Remove the oldest entry |
| rd_data | output | 8 | Data byte of the oldest entry |
| rd_parity_err | output | 1 | Parity flag of the oldest entry |
| rd_frame_err | output | 1 | Framing flag of the oldest entry |
| fill_level | output | 5 | Number of stored entries |
| err_entries | output | 5 | Number of stored entries with an error flag |
| irq_rx_full | output | 1 | Fill level at or above threshold |
| irq_rx_err | output | 1 | At least one stored entry is flagged |
| irq_break | output | 1 | Break condition on the line |
| rx_timeout | output | 1 | Stored data left idle too long |
| overrun | output | 1 | Sticky: a character was lost to a full queue |
| rts | output | 1 | Flow control, 1 while fill is below 14 |

## Verification
On every cycle, the assertions check these points: the fill count moves by exactly one on each store or read; the error count never exceeds the fill count; a character that meets a full queue leaves the overrun flag set; the overrun flag never clears; the time-out and ready requests never appear with an empty queue; and a break begins only on a low line. Other behaviour can only be shown by the bench's scenarios: the bit order, 7-bit masking, parity polarity, start-bit rejection of a short glitch, threshold decoding, the exact length of the break and idle windows, and the order of stored entries. A behavioural queue model in the bench is compared with the ports on every clock once each frame has settled.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef struct packed {
    logic       perr;
    logic       ferr;
    logic [7:0] data;
  } rx_entry_t;

  // Total bits in one frame: start + data + parity + stop bits
  function automatic logic [3:0] frame_bits(input logic seven, input logic par_en,
                                            input logic two_stop);
    return 4'd1 + (seven ? 4'd7 : 4'd8) + {3'b000, par_en} + (two_stop ? 4'd2 : 4'd1);
  endfunction

  // Expected parity bit for a byte (upper bit already masked in 7-bit mode)
  function automatic logic par_expect(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // Receive-ready threshold decode
  function automatic logic [4:0] thr_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  function automatic logic has_err(input rx_entry_t e);
    return e.perr | e.ferr;
  endfunction

endpackage

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       cfg_seven,
  input  logic       cfg_two_stop,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  output logic       rxd_s,
  output logic       start_det,
  output logic       frame_done,
  output rx_entry_t  frame_entry,
  output logic       brk
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(12 * OSR + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BITS, S_BRKW, S_BRK} st_t;

  st_t            st;
  logic [1:0]     sync_q;
  logic [CW-1:0]  tcnt;
  logic [3:0]     bidx;
  logic [7:0]     shreg;
  logic           par_rx;
  logic [BW-1:0]  bcnt;
  logic [3:0]     dlen;
  logic [BW-1:0]  frame_ticks;
  logic [7:0]     masked;

  assign rxd_s       = sync_q[1];
  assign dlen        = cfg_seven ? 4'd7 : 4'd8;
  assign frame_ticks = BW'(frame_bits(cfg_seven, cfg_par_en, cfg_two_stop)) * BW'(OSR);
  assign masked      = cfg_seven ? {1'b0, shreg[6:0]} : shreg;
  assign start_det   = (st == S_IDLE) && tick && !rxd_s;
  assign brk         = (st == S_BRK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= 2'b11;
      st          <= S_IDLE;
      tcnt        <= '0;
      bidx        <= '0;
      shreg       <= '0;
      par_rx      <= 1'b0;
      bcnt        <= '0;
      frame_done  <= 1'b0;
      frame_entry <= '0;
    end else begin
      sync_q     <= {sync_q[0], rxd};
      frame_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_det) begin
            st   <= S_START;
            tcnt <= '0;
          end
        end
        S_START: begin
          if (tick) begin
            if (tcnt == MID) begin
              tcnt <= '0;
              if (!rxd_s) begin
                st    <= S_BITS;
                bidx  <= '0;
                shreg <= '0;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        S_BITS: begin
          if (tick) begin
            if (tcnt == LAST) begin
              tcnt <= '0;
              bidx <= bidx + 1'b1;
              if (bidx < dlen) begin
                shreg[bidx[2:0]] <= rxd_s;
              end else if (cfg_par_en && bidx == dlen) begin
                par_rx <= rxd_s;
              end else begin
                frame_done       <= 1'b1;
                frame_entry.data <= masked;
                frame_entry.perr <= cfg_par_en && (par_rx != par_expect(masked, cfg_par_odd));
                frame_entry.ferr <= !rxd_s;
                if (!rxd_s) begin
                  st   <= S_BRKW;
                  bcnt <= '0;
                end else begin
                  st <= S_IDLE;
                end
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        S_BRKW: begin
          if (rxd_s) begin
            st <= S_IDLE;
          end else if (tick) begin
            if (bcnt == frame_ticks - 1'b1) st <= S_BRK;
            else                            bcnt <= bcnt + 1'b1;
          end
        end
        S_BRK: begin
          if (rxd_s) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  rx_entry_t                  push_entry,
  input  logic                       pop,
  output rx_entry_t                  head,
  output logic [$clog2(DEPTH):0]     fill,
  output logic [$clog2(DEPTH):0]     err_cnt,
  output logic                       full,
  output logic                       push_ok,
  output logic                       pop_ok
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wr_ptr;
  logic [AW-1:0]   rd_ptr;
  logic [CW-1:0]   err_in;
  logic [CW-1:0]   err_out;

  assign full    = (fill == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (fill != '0);
  assign head    = mem[rd_ptr];
  assign err_in  = CW'(push_ok && has_err(push_entry));
  assign err_out = CW'(pop_ok && has_err(head));

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill    <= '0;
      err_cnt <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      fill    <= fill + CW'(push_ok) - CW'(pop_ok);
      err_cnt <= err_cnt + err_in - err_out;
    end
  end
endmodule

// File: rtl/serial_rx_idle_timer.sv
module serial_rx_idle_timer
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic data_held,
  input  logic cfg_seven,
  input  logic cfg_two_stop,
  input  logic cfg_par_en,
  output logic timeout
);
  localparam int TW = $clog2(12 * OSR * 3 / 2 + 1);

  logic [TW-1:0] cnt;
  logic [TW-1:0] limit;

  assign limit   = TW'(frame_bits(cfg_seven, cfg_par_en, cfg_two_stop)) * TW'(OSR * 3 / 2);
  assign timeout = data_held && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (restart)              cnt <= '0;
    else if (tick && cnt < limit)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/serial_rx_errfifo.sv
module serial_rx_errfifo
  import serial_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DEPTH     = 16,
  parameter int RTS_LEVEL = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       cfg_seven_bit,
  input  logic       cfg_two_stop,
  input  logic       cfg_parity_en,
  input  logic       cfg_parity_odd,
  input  logic [1:0] cfg_full_sel,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic       rd_parity_err,
  output logic       rd_frame_err,
  output logic [4:0] fill_level,
  output logic [4:0] err_entries,
  output logic       irq_rx_full,
  output logic       irq_rx_err,
  output logic       irq_break,
  output logic       rx_timeout,
  output logic       overrun,
  output logic       rts
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          rxd_s;
  logic          start_det;
  logic          frame_done;
  rx_entry_t     fr_entry;
  rx_entry_t     head;
  logic [CW-1:0] fill;
  logic [CW-1:0] err_cnt;
  logic          fifo_full;
  logic          push_ok;
  logic          pop_ok;

  serial_rx_framer #(.OSR(OSR)) framer_i (
    .clk, .rst_n, .tick(baud_tick), .rxd,
    .cfg_seven(cfg_seven_bit), .cfg_two_stop, .cfg_par_en(cfg_parity_en),
    .cfg_par_odd(cfg_parity_odd), .rxd_s, .start_det, .frame_done,
    .frame_entry(fr_entry), .brk(irq_break)
  );

  serial_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk, .rst_n, .push(frame_done), .push_entry(fr_entry), .pop(rd_pop),
    .head, .fill, .err_cnt, .full(fifo_full), .push_ok, .pop_ok
  );

  serial_rx_idle_timer #(.OSR(OSR)) timer_i (
    .clk, .rst_n, .tick(baud_tick), .restart(push_ok | pop_ok | start_det),
    .data_held(fill != '0), .cfg_seven(cfg_seven_bit), .cfg_two_stop,
    .cfg_par_en(cfg_parity_en), .timeout(rx_timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       overrun <= 1'b0;
    else if (frame_done && fifo_full) overrun <= 1'b1;
  end

  assign rd_data       = head.data;
  assign rd_parity_err = head.perr;
  assign rd_frame_err  = head.ferr;
  assign fill_level    = 5'(fill);
  assign err_entries   = 5'(err_cnt);
  assign irq_rx_err    = (err_cnt != '0);
  assign irq_rx_full   = (fill >= CW'(thr_level(cfg_full_sel)));
  assign rts           = (fill < CW'(RTS_LEVEL));
endmodule

// File: rtl/serial_rx_errfifo_chk.sv
module serial_rx_errfifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rxd_s,
  input logic [$clog2(DEPTH):0] fill,
  input logic [$clog2(DEPTH):0] err_cnt,
  input logic                   push_ok,
  input logic                   pop_ok,
  input logic                   frame_done,
  input logic                   fifo_full,
  input logic                   ovr,
  input logic                   brk,
  input logic                   timeout,
  input logic                   full_irq
);
  // R5
  fill_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && !pop_ok |=> fill == $past(fill) + 1'b1);

  // R5
  fill_step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok && !push_ok |=> fill == $past(fill) - 1'b1);

  // R6
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= fill);

  // R7
  full_irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_irq |-> fill != '0);

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && fifo_full |=> ovr);

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);

  // R10
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk) |-> !rxd_s);

  // R11
  timeout_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> fill != '0);
endmodule

bind serial_rx_errfifo serial_rx_errfifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .rxd_s(rxd_s), .fill(fill), .err_cnt(err_cnt),
  .push_ok(push_ok), .pop_ok(pop_ok), .frame_done(frame_done),
  .fifo_full(fifo_full), .ovr(overrun), .brk(irq_break),
  .timeout(rx_timeout), .full_irq(irq_rx_full)
);

// File: tb/serial_rx_errfifo_tb_top.sv
module serial_rx_errfifo_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic rxd = 1'b1;
  logic cfg_seven_bit = 1'b0, cfg_two_stop = 1'b0, cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0;
  logic [1:0] cfg_full_sel = 2'd0;
  logic rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_parity_err, rd_frame_err;
  logic [4:0] fill_level, err_entries;
  logic irq_rx_full, irq_rx_err, irq_break, rx_timeout, overrun, rts;

  always #2 clk = ~clk;

  serial_rx_errfifo dut_i (
    .clk, .rst_n, .baud_tick, .rxd, .cfg_seven_bit, .cfg_two_stop, .cfg_parity_en,
    .cfg_parity_odd, .cfg_full_sel, .rd_pop, .rd_data, .rd_parity_err, .rd_frame_err,
    .fill_level, .err_entries, .irq_rx_full, .irq_rx_err, .irq_break, .rx_timeout,
    .overrun, .rts
  );

  typedef struct {bit [7:0] d; bit pe; bit fe;} ent_t;
  ent_t mq[$];
  bit   m_ovr = 0;
  bit   sync = 0;
  int   n_run = 0, n_fail = 0, cyc = 0, tdiv = 0;
  bit   done = 0;

  // 16 ticks per bit, one tick every 4 clocks
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    baud_tick <= (tdiv == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int thr_of(input int sel);
    int t[4] = '{1, 4, 8, 14};
    return t[sel];
  endfunction

  function automatic int model_errs();
    int n = 0;
    foreach (mq[i]) if (mq[i].pe || mq[i].fe) n++;
    return n;
  endfunction

  // Per-clock comparison against the queue model
  always @(posedge clk) begin
    #1;
    if (sync && !done) begin
      chk(fill_level == mq.size(), "R5 fill", fill_level, mq.size());
      chk(err_entries == model_errs(), "R6 err_entries", err_entries, model_errs());
      chk(irq_rx_err == (model_errs() != 0), "R6 irq_rx_err", irq_rx_err, model_errs() != 0);
      chk(irq_rx_full == (mq.size() >= thr_of(cfg_full_sel)), "R7 irq_rx_full",
          irq_rx_full, mq.size() >= thr_of(cfg_full_sel));
      chk(rts == (mq.size() < 14), "R8 rts", rts, mq.size() < 14);
      chk(overrun == m_ovr, "R9 overrun", overrun, m_ovr);
      if (mq.size() > 0)
        chk({rd_parity_err, rd_frame_err, rd_data} == {mq[0].pe, mq[0].fe, mq[0].d},
            "R5 head", {rd_parity_err, rd_frame_err, rd_data}, {mq[0].pe, mq[0].fe, mq[0].d});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic put_bit(input bit b);
    rxd = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic send_char(input bit [7:0] d, input bit bad_par, input bit bad_stop,
                           input bit hold_low);
    bit [7:0] m; bit p; int dl; ent_t e;
    sync = 0;
    @(negedge clk);
    dl = cfg_seven_bit ? 7 : 8;
    m  = cfg_seven_bit ? {1'b0, d[6:0]} : d;
    p  = (^m) ^ cfg_parity_odd ^ bad_par;
    put_bit(0);
    for (int i = 0; i < dl; i++) put_bit(d[i]);
    if (cfg_parity_en) put_bit(p);
    put_bit(!bad_stop);
    if (cfg_two_stop && !bad_stop) put_bit(1);
    if (!hold_low) rxd = 1;
    e.d = m; e.pe = bad_par && cfg_parity_en; e.fe = bad_stop;
    if (mq.size() < 16) mq.push_back(e); else m_ovr = 1;
    repeat (4) @(negedge clk);
    if (!hold_low) sync = 1;
  endtask

  task automatic do_pop();
    sync = 0;
    @(negedge clk);
    rd_pop = 1;
    @(negedge clk);
    rd_pop = 0;
    if (mq.size() > 0) void'(mq.pop_front());
    sync = 1;
  endtask

  task automatic drain();
    while (mq.size() > 0) do_pop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(fill_level == 0 && err_entries == 0, "R5 reset fill", fill_level, 0);
    chk(rts == 1 && !irq_rx_full && !irq_break && !rx_timeout && !overrun,
        "R8 reset flags", {rts, irq_rx_full, irq_break, rx_timeout, overrun}, 5'b10000);
    sync = 1;

    // R2: 8N1 bit order
    send_char(8'hA5, 0, 0, 0);
    send_char(8'h3C, 0, 0, 0);
    chk(rd_data == 8'hA5, "R2 first byte", rd_data, 8'hA5);
    do_pop();
    chk(rd_data == 8'h3C, "R5 order", rd_data, 8'h3C);
    do_pop();

    // R2/R3: 7-bit even parity, bit 7 reads 0
    cfg_seven_bit = 1; cfg_parity_en = 1;
    send_char(8'hD5, 0, 0, 0);
    chk(rd_data == 8'h55 && !rd_parity_err, "R2 seven-bit mask", rd_data, 8'h55);
    send_char(8'h13, 1, 0, 0);
    do_pop();
    chk(rd_parity_err == 1, "R3 even parity mismatch", rd_parity_err, 1);
    do_pop();

    // R3: odd parity, 8 bit
    cfg_seven_bit = 0; cfg_parity_odd = 1;
    send_char(8'h81, 0, 0, 0);
    chk(!rd_parity_err && rd_data == 8'h81, "R3 odd parity good", rd_parity_err, 0);
    send_char(8'h7E, 1, 0, 0);
    chk(err_entries == 1, "R6 one flagged entry", err_entries, 1);
    drain();

    // R4: two stop bits, then a framing error released high
    cfg_parity_en = 0; cfg_parity_odd = 0; cfg_two_stop = 1;
    send_char(8'h5A, 0, 0, 0);
    send_char(8'hC3, 0, 0, 0);
    chk(!rd_frame_err && fill_level == 2, "R4 two stop clean", rd_frame_err, 0);
    cfg_two_stop = 0;
    send_char(8'h0F, 0, 1, 0);
    repeat (50) @(negedge clk);
    chk(irq_break == 0, "R10 no break when line high", irq_break, 0);
    do_pop(); do_pop();
    chk(rd_frame_err == 1, "R4 framing flag", rd_frame_err, 1);
    drain();

    // R1: short glitch ignored
    @(negedge clk); rxd = 0;
    repeat (12) @(negedge clk); rxd = 1;
    repeat (200) @(negedge clk);
    chk(fill_level == 0, "R1 glitch stores nothing", fill_level, 0);

    // R11: idle time-out
    send_char(8'h11, 0, 0, 0);
    repeat (500) @(negedge clk);
    chk(rx_timeout == 0, "R11 before window", rx_timeout, 0);
    repeat (600) @(negedge clk);
    chk(rx_timeout == 1, "R11 after window", rx_timeout, 1);
    do_pop();
    @(negedge clk);
    chk(rx_timeout == 0, "R11 cleared by read", rx_timeout, 0);

    // R7/R8/R9: threshold 4, fill to 16, overrun
    cfg_full_sel = 2'd1;
    for (int k = 0; k < 3; k++) send_char(8'(k + 1), 0, 0, 0);
    chk(irq_rx_full == 0, "R7 below threshold", irq_rx_full, 0);
    send_char(8'h04, 0, 0, 0);
    chk(irq_rx_full == 1, "R7 at threshold", irq_rx_full, 1);
    for (int k = 4; k < 13; k++) send_char(8'(k + 1), 0, 0, 0);
    chk(rts == 1, "R8 rts at 13", rts, 1);
    send_char(8'h0E, 0, 0, 0);
    chk(rts == 0, "R8 rts at 14", rts, 0);
    send_char(8'h0F, 0, 0, 0);
    send_char(8'h10, 0, 0, 0);
    chk(overrun == 0 && fill_level == 16, "R9 full no overrun", overrun, 0);
    send_char(8'hEE, 0, 0, 0);
    chk(overrun == 1 && fill_level == 16, "R9 overrun on 17th", overrun, 1);
    chk(rd_data == 8'h01, "R9 head unchanged", rd_data, 8'h01);
    drain();
    cfg_full_sel = 2'd0;

    // R10: break
    send_char(8'h00, 0, 1, 1);
    repeat (800) @(negedge clk);
    chk(irq_break == 1, "R10 break raised", irq_break, 1);
    rxd = 1;
    repeat (8) @(negedge clk);
    chk(irq_break == 0, "R10 break released", irq_break, 0);
    sync = 1;
    chk(rd_frame_err == 1 && rd_data == 8'h00, "R10 break char flagged", rd_frame_err, 1);
    drain();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule